// File: doc/BRIEF.md
# Dual Programmable Down-Counting Timer

A memory-mapped peripheral with two independent timer channels, reached through a flat 32-bit register port that has an address, a write strobe, write data and combinational read data. Each channel holds a counter that steps downward once per prescaled tick. The counter is either 16 or 32 bits wide. When it reaches zero, the channel either reloads from its reload value (periodic), wraps to the all-ones value of its width (free-running), or parks at zero (one-shot). Reaching zero raises a sticky raw flag. The flag, gated by the channel's interrupt enable, drives that channel's interrupt line and one OR-combined line.

Software sets the timers up through a load register and a background-load register. A write to the load register restarts the count at once. A write to the background-load register only changes the value used at the next periodic reload. A row of read-only identification bytes lets software recognise the block. Each channel is sequenced by a three-state controller. ST_HALT means the counter is frozen. ST_RUN means the counter steps on each tick. ST_DONE means a one-shot count has ended. The transitions are:
- HALT→RUN: a control write with the enable set, or a load write while enabled.
- RUN→HALT and DONE→HALT: a control write with the enable clear, or a load write while disabled.
- RUN→DONE: a one-shot tick that reaches zero, or a one-shot tick taken at zero.
- DONE→RUN: a load write or a control write with the enable set.

Top module: `dual_timer`

## Requirements
- R1: Channel 0 registers sit at word offsets 0x00 load, 0x04 count, 0x08 control, 0x0C interrupt clear, 0x10 raw flag (bit 0), 0x14 masked flag (bit 0) and 0x18 background load. Channel 1 repeats this layout at 0x20. The clear register and any unmapped address read as zero.
- R2: Control bits are as follows. Bit 7 is enable. Bit 6 selects periodic (1) or free-running (0). Bit 5 is interrupt enable. Bits 3:2 select the prescaler. Bit 1 selects 32-bit width (0 means 16-bit). Bit 0 selects one-shot, which takes precedence over bit 6. Bit 4 is not stored and reads as 0.
- R3: After reset, control reads 0x20, the count reads 0x0000FFFF, the raw flags are 0, and all interrupt outputs are low.
- R4: Each tick lowers the count by one. In 16-bit mode only bits 15:0 count, and bits 31:16 of the count read as zero.
- R5: Prescaler select 00 gives a tick every clock, 01 every 16 clocks, and 10 or 11 every 256 clocks. A load or control write restarts the prescaler phase, so the first tick falls on the N-th edge after that write, where N is the division.
- R6: A load write sets the count to the written value, masked to the width, and sets the reload value. A background-load write sets only the reload value. Offsets 0x00 and 0x18 both read back the reload value.
- R7: A tick taken at a count of zero does one of three things. In periodic mode it reloads the count from the reload value. In free-running mode it wraps the count to 0xFFFF or 0xFFFFFFFF. In one-shot mode it leaves the count at zero with no further ticks until a load or control write.
- R8: A tick that takes the count from 1 to 0 sets the raw flag. The masked flag equals raw AND interrupt enable. irq_ch[n] is channel n's masked flag, and irq_any is the OR of both.
- R9: Any write to the clear register clears the raw flag. When the same cycle also brings a new zero, the flag stays set.
- R10: Clearing the enable freezes the count. Setting it again resumes from the frozen value.
- R11: The eight word addresses 0xFE0 to 0xFFC return one byte each in bits 7:0. The first four return ID_PERIPH and the last four return ID_CELL, each starting with the least significant byte.
- R12: Writes to the count register are ignored. A load or control write in a cycle where a tick was due replaces that tick, so there is no step and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the register word |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq_ch | output | NUM_CH | Per-channel masked interrupt |
| irq_any | output | 1 | OR of all channel interrupts |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an interrupt-clear write and a step that takes the count to zero. The second pair is a load or control write and a tick that was already due. The bench counts edges from a periodic load of four and places the clear strobe exactly on the edge of the fourth step. It then expects the raw flag to read 1. It also writes a new load value while the channel steps every clock and expects the written value, not value minus one. A behavioural model, stepped every clock, compares read data and all interrupt lines throughout.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_t;

    localparam int CTL_EN   = 7;
    localparam int CTL_PER  = 6;
    localparam int CTL_IE   = 5;
    localparam int CTL_DIVH = 3;
    localparam int CTL_DIVL = 2;
    localparam int CTL_WIDE = 1;
    localparam int CTL_ONE  = 0;

    localparam logic [7:0] CTL_RESET = 8'h20;
    localparam logic [7:0] CTL_WMASK = 8'hEF;

    localparam logic [2:0] REG_LOAD = 3'd0;
    localparam logic [2:0] REG_CNT  = 3'd1;
    localparam logic [2:0] REG_CTL  = 3'd2;
    localparam logic [2:0] REG_CLR  = 3'd3;
    localparam logic [2:0] REG_RAW  = 3'd4;
    localparam logic [2:0] REG_MIS  = 3'd5;
    localparam logic [2:0] REG_BG   = 3'd6;
endpackage

// File: rtl/dtim_prescale.sv
module dtim_prescale #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam logic [PRE_W-1:0] LIM_16  = PRE_W'(15);
    localparam logic [PRE_W-1:0] LIM_256 = PRE_W'(255);

    logic [PRE_W-1:0] lim;
    logic [PRE_W-1:0] phase_q;

    always_comb begin
        unique case (sel)
            2'b00:   lim = '0;
            2'b01:   lim = LIM_16;
            default: lim = LIM_256;
        endcase
    end

    assign tick = run && !restart && (phase_q == lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == lim) ? '0 : phase_q + PRE_W'(1);
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim != '0 && !restart) |=> !tick); // R5
endmodule

// File: rtl/dtim_channel.sv
module dtim_channel
    import dtim_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load,
    input  logic             wr_bg,
    input  logic             wr_ctl,
    input  logic             wr_clr,
    input  logic [CNT_W-1:0] wdata,
    output logic [7:0]       ctl_o,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] val_o,
    output logic             raw_o,
    output logic             mis_o
);
    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] MASK_NARROW = {{(CNT_W-HALF){1'b0}}, {HALF{1'b1}}};

    run_state_t       state_q, state_d;
    logic [7:0]       ctl_q;
    logic [CNT_W-1:0] rel_q, cnt_q, mask, cur, dec;
    logic             raw_q, tick, restart, at_zero, at_one, hit;

    assign mask    = ctl_q[CTL_WIDE] ? '1 : MASK_NARROW;
    assign cur     = cnt_q & mask;
    assign dec     = (cur - CNT_W'(1)) & mask;
    assign at_zero = (cur == '0);
    assign at_one  = (cur == CNT_W'(1));
    assign restart = wr_load | wr_ctl;
    assign hit     = tick && at_one;

    dtim_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_RUN),
        .restart (restart),
        .sel     (ctl_q[CTL_DIVH:CTL_DIVL]),
        .tick    (tick)
    );

    always_comb begin
        state_d = state_q;
        if (wr_ctl) begin
            state_d = wdata[CTL_EN] ? ST_RUN : ST_HALT;
        end else if (wr_load) begin
            state_d = ctl_q[CTL_EN] ? ST_RUN : ST_HALT;
        end else begin
            unique case (state_q)
                ST_RUN:  if (tick && ctl_q[CTL_ONE] && (at_zero || at_one)) state_d = ST_DONE;
                ST_HALT: state_d = ST_HALT;
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
            rel_q <= '0;
            cnt_q <= '1;
            raw_q <= 1'b0;
        end else begin
            if (wr_ctl) ctl_q <= wdata[7:0] & CTL_WMASK;
            if (wr_load || wr_bg) rel_q <= wdata;
            if (wr_load) begin
                cnt_q <= wdata & mask;
            end else if (tick) begin
                if (!at_zero)              cnt_q <= dec;
                else if (ctl_q[CTL_ONE])   cnt_q <= cnt_q;
                else if (ctl_q[CTL_PER])   cnt_q <= rel_q & mask;
                else                       cnt_q <= mask;
            end
            if (hit)         raw_q <= 1'b1;
            else if (wr_clr) raw_q <= 1'b0;
        end
    end

    assign ctl_o  = ctl_q;
    assign load_o = rel_q;
    assign val_o  = cur;
    assign raw_o  = raw_q;
    assign mis_o  = raw_q & ctl_q[CTL_IE];

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !wr_load) |=> $stable(cnt_q)); // R7
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !wr_load) |=> $stable(cnt_q)); // R10
    AST_ZERO_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && val_o != '0) |=> (val_o != '0 || raw_o)); // R8
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_o && !wr_clr) |=> raw_o); // R9
endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtim_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          NUM_CH    = 2,
    parameter int          PRE_W     = 8,
    parameter logic [31:0] ID_PERIPH = 32'h0A5C_3301,
    parameter logic [31:0] ID_CELL   = 32'hB105_F00D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] irq_ch,
    output logic              irq_any
);
    localparam int CH_LSB = 5;
    localparam int CSEL_W = ADDR_W - CH_LSB;
    localparam logic [63:0] ID_ALL = {ID_CELL, ID_PERIPH};

    logic [CSEL_W-1:0] csel;
    logic [2:0]        woff;
    logic              id_hit;
    logic              unused_lsb;

    logic [7:0]  ctl_a  [NUM_CH];
    logic [31:0] load_a [NUM_CH];
    logic [31:0] val_a  [NUM_CH];
    logic [NUM_CH-1:0] raw_a, mis_a;

    assign csel       = addr[ADDR_W-1:CH_LSB];
    assign woff       = addr[CH_LSB-1:2];
    assign id_hit     = (csel == '1);
    assign unused_lsb = ^addr[1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_c;
        assign sel_c = wr_en && (csel == CSEL_W'(c));

        dtim_channel #(.CNT_W(32), .PRE_W(PRE_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_load (sel_c && woff == REG_LOAD),
            .wr_bg   (sel_c && woff == REG_BG),
            .wr_ctl  (sel_c && woff == REG_CTL),
            .wr_clr  (sel_c && woff == REG_CLR),
            .wdata   (wdata),
            .ctl_o   (ctl_a[c]),
            .load_o  (load_a[c]),
            .val_o   (val_a[c]),
            .raw_o   (raw_a[c]),
            .mis_o   (mis_a[c])
        );
    end

    always_comb begin
        rdata = '0;
        if (id_hit) begin
            rdata = {24'd0, ID_ALL[{woff, 3'b000} +: 8]};
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (csel == CSEL_W'(c)) begin
                    unique case (woff)
                        REG_LOAD, REG_BG: rdata = load_a[c];
                        REG_CNT:          rdata = val_a[c];
                        REG_CTL:          rdata = {24'd0, ctl_a[c]};
                        REG_RAW:          rdata = {31'd0, raw_a[c]};
                        REG_MIS:          rdata = {31'd0, mis_a[c]};
                        default:          rdata = '0;
                    endcase
                end
            end
        end
    end

    assign irq_ch  = mis_a;
    assign irq_any = |mis_a;
endmodule

// File: tb/dual_timer_bench.sv
module dual_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq_ch;
    logic        irq_any;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dual_timer u_dual_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .irq_ch(irq_ch), .irq_any(irq_any)
    );

    // behavioural reference model
    bit [31:0] m_cur [2];
    bit [31:0] m_rel [2];
    bit [7:0]  m_ctl [2];
    bit        m_raw [2];
    int        m_pre [2];
    bit        m_done[2];

    always @(posedge clk) begin
        for (int c = 0; c < 2; c++) begin
            bit sel, tick, hit;
            int off, lim;
            bit [31:0] msk, cv;
            if (!rst_n) begin
                m_ctl[c] = 8'h20; m_rel[c] = 0; m_cur[c] = 32'hFFFF_FFFF;
                m_raw[c] = 0; m_pre[c] = 0; m_done[c] = 0;
            end else begin
                sel  = wr_en && (addr < 12'h040) && (addr[5] == (c == 1));
                off  = int'(addr[4:2]);
                msk  = m_ctl[c][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                lim  = (m_ctl[c][3:2] == 0) ? 0 : (m_ctl[c][3:2] == 1) ? 15 : 255;
                tick = 0; hit = 0;
                if (sel && (off == 0 || off == 2)) m_pre[c] = 0;
                else if (m_ctl[c][7] && !m_done[c]) begin
                    if (m_pre[c] == lim) begin m_pre[c] = 0; tick = 1; end
                    else m_pre[c] = m_pre[c] + 1;
                end
                if (tick) begin
                    cv = m_cur[c] & msk;
                    if (cv == 0) begin
                        if (m_ctl[c][0]) m_done[c] = 1;
                        else if (m_ctl[c][6]) m_cur[c] = m_rel[c] & msk;
                        else m_cur[c] = msk;
                    end else begin
                        m_cur[c] = (cv - 1) & msk;
                        if (m_cur[c] == 0) begin hit = 1; if (m_ctl[c][0]) m_done[c] = 1; end
                    end
                end
                if (sel) begin
                    case (off)
                        0: begin m_rel[c] = wdata; m_cur[c] = wdata & msk; m_done[c] = 0; end
                        2: begin m_ctl[c] = wdata[7:0] & 8'hEF; m_done[c] = 0; end
                        3: if (!hit) m_raw[c] = 0;
                        6: m_rel[c] = wdata;
                        default: ;
                    endcase
                end
                if (hit) m_raw[c] = 1;
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        logic [63:0] ids = {32'hB105_F00D, 32'h0A5C_3301};
        int c = int'(a[5]);
        bit [31:0] msk = m_ctl[c][1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        if (a[11:5] == 7'h7F) return {24'd0, ids[8*a[4:2] +: 8]};
        if (a >= 12'h040) return 0;
        case (a[4:2])
            0, 6: return m_rel[c];
            1: return m_cur[c] & msk;
            2: return {24'd0, m_ctl[c]};
            4: return {31'd0, m_raw[c]};
            5: return {31'd0, m_raw[c] & m_ctl[c][5]};
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(logic [11:0] a);
        if (a[11:5] == 7'h7F) return "R11";
        if (a >= 12'h040) return "R1";
        case (a[4:2])
            0, 6: return "R6";
            1: return "R4";
            2: return "R2";
            4, 5: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            check(tag_of(addr), rdata, exp_rd(addr), "model rdata");
            check("R8", {29'd0, irq_any, irq_ch},
                  {29'd0, (m_raw[0] & m_ctl[0][5]) | (m_raw[1] & m_ctl[1][5]),
                   m_raw[1] & m_ctl[1][5], m_raw[0] & m_ctl[0][5]}, "model irq");
        end
    end

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_rd(logic [11:0] a, logic [31:0] exp, string tag);
        addr = a; wr_en = 1'b0;
        #1;
        check(tag, rdata, exp, "directed read");
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R3 reset state
        chk_rd(12'h008, 32'h20, "R3");
        chk_rd(12'h004, 32'h0000_FFFF, "R3");
        chk_rd(12'h010, 32'h0, "R3");
        chk_rd(12'h024, 32'h0000_FFFF, "R3");
        check("R3", {30'd0, irq_ch}, 32'd0, "irq after reset");
        // R1 / R11 map and identification
        chk_rd(12'h00C, 32'h0, "R1");
        chk_rd(12'h100, 32'h0, "R1");
        chk_rd(12'hFE0, 32'h01, "R11");
        chk_rd(12'hFEC, 32'h0A, "R11");
        chk_rd(12'hFF0, 32'h0D, "R11");
        chk_rd(12'hFFC, 32'hB1, "R11");

        // channel 0 periodic, div 1
        bus_write(12'h000, 32'd4);
        bus_write(12'h008, 32'hE2);
        idle(4);
        chk_rd(12'h004, 32'd0, "R8");
        check("R8", {31'd0, irq_ch[0]}, 32'd1, "irq ch0 at zero");
        idle(1);
        chk_rd(12'h004, 32'd4, "R7");
        bus_write(12'h00C, 32'd0);
        chk_rd(12'h010, 32'd0, "R9");
        idle(2);
        bus_write(12'h00C, 32'd0); // lands on the zero step
        chk_rd(12'h010, 32'd1, "R9");
        chk_rd(12'h004, 32'd0, "R9");
        idle(2);
        bus_write(12'h008, 32'h00);
        chk_rd(12'h004, 32'd3, "R10");
        idle(5);
        chk_rd(12'h004, 32'd3, "R10");
        bus_write(12'h008, 32'hE2);
        chk_rd(12'h004, 32'd3, "R10");
        idle(1);
        chk_rd(12'h004, 32'd2, "R10");
        bus_write(12'h000, 32'd7);
        chk_rd(12'h004, 32'd7, "R12");
        bus_write(12'h008, 32'hE6);
        idle(15);
        chk_rd(12'h004, 32'd7, "R5");
        idle(1);
        chk_rd(12'h004, 32'd6, "R5");
        bus_write(12'h008, 32'hEA);
        idle(255);
        chk_rd(12'h004, 32'd6, "R5");
        idle(1);
        chk_rd(12'h004, 32'd5, "R5");

        // channel 1 free-running 16-bit, interrupt disabled
        bus_write(12'h020, 32'd2);
        bus_write(12'h028, 32'h80);
        idle(2);
        chk_rd(12'h024, 32'd0, "R4");
        chk_rd(12'h030, 32'd1, "R8");
        chk_rd(12'h034, 32'd0, "R8");
        check("R8", {31'd0, irq_ch[1]}, 32'd0, "masked irq ch1");
        idle(1);
        chk_rd(12'h024, 32'h0000_FFFF, "R7");
        bus_write(12'h028, 32'h00);
        bus_write(12'h02C, 32'h0);
        // 32-bit wrap
        bus_write(12'h020, 32'd1);
        bus_write(12'h028, 32'h82);
        idle(2);
        chk_rd(12'h024, 32'hFFFF_FFFF, "R7");
        bus_write(12'h028, 32'h00);
        bus_write(12'h02C, 32'h0);
        // one-shot
        bus_write(12'h020, 32'd2);
        bus_write(12'h028, 32'hA1);
        idle(5);
        chk_rd(12'h024, 32'd0, "R7");
        check("R8", {30'd0, irq_any, irq_ch[1]}, 32'd3, "irq ch1 and any");
        bus_write(12'h020, 32'd3);
        chk_rd(12'h024, 32'd3, "R6");
        bus_write(12'h038, 32'd9);
        chk_rd(12'h024, 32'd2, "R6");
        chk_rd(12'h020, 32'd9, "R6");
        chk_rd(12'h038, 32'd9, "R6");
        bus_write(12'h024, 32'h55);
        chk_rd(12'h024, 32'd1, "R12");
        idle(1);
        chk_rd(12'h024, 32'd0, "R7");
        idle(3);
        chk_rd(12'h024, 32'd0, "R7");
        // control bit 4 not stored
        bus_write(12'h028, 32'h10);
        chk_rd(12'h028, 32'h00, "R2");
        bus_write(12'h028, 32'h5F);
        chk_rd(12'h028, 32'h4F, "R2");

        addr = 12'h004;
        idle(300);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule